// File: doc/BRIEF.md
# Multiplier-Free Symmetric FIR Filter

This block is a linear-phase finite impulse response filter. It forms every output sample from table lookups, shifts and additions, and it has no hardware multipliers. Each sample that arrives with its qualifier enters a tap delay line. The two taps that share a coefficient are summed first. Each bit of those pair sums, across all pairs, then addresses a small precomputed table. Every bit position is evaluated at the same time. A pipelined adder tree adds the weighted plane results, so the filter can take a new sample on every clock.

The coefficients are a parameter of the block. At elaboration each table's contents are computed from that parameter. Changing the coefficient set therefore turns the same structure into a low-pass, high-pass or band-pass filter. The default configuration has 16 taps (8 mirrored pairs), 8-bit two's-complement samples and 10-bit signed coefficients. The tables are split into partitions of 4 pairs, so each partition holds 16 entries. The output keeps full precision on 22 bits.

Top module: `dasym_fir`

## Requirements
- R1: While reset is asserted, and until the first accepted sample has passed through the pipeline, out_valid is 0 and out_data is 0. The tap history starts at all zeros.
- R2: For each accepted sample x(n), out_data equals y(n) = Σ h(k)·x(n−k) for k = 0..15, as a signed 22-bit value with no rounding. Here h(k) = h(15−k), and h(k) for k = 0..7 is the 10-bit signed field COEFS[10k+9:10k]. An impulse therefore produces h(0), h(1), …, h(7), h(7), …, h(0).
- R3: out_valid is 1 exactly on the cycle after the 7th rising edge that follows the edge that accepted the sample. There is exactly one output per accepted sample, and outputs come in input order.
- R4: A cycle with in_valid = 0 does not change the tap history. in_data in that cycle has no effect on any later output.
- R5: While out_valid is 0, out_data holds the value of the last valid output.
- R6: in_data is two's complement. The value 8'h80 (−128) is handled as −128, both alone and as a sustained input.
- R7: A different COEFS value changes the response with no change to the structure or the latency. A high-pass set that contains the extreme values +511 and −512 gives the exact R2 result.
- R8: Samples accepted on consecutive cycles produce outputs on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies in_data for this cycle |
| in_data | input | 8 | Input sample, two's complement |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | 22 | Filtered sample, two's complement, full precision |

## Verification
The result for a sample driven before rising edge C+1 is due 8 edges later. The bench samples it on the falling edge at which its own edge counter reads C+8. Every accepted sample pushes its due cycle and its reference values onto queues. On each falling edge the bench compares out_valid against whether the head of the queue is due. When the head is due, it compares the data of both configurations. On all other falling edges it checks that the data is unchanged.

// File: rtl/dasym_fir_pkg.sv
package dasym_fir_pkg;

  // Smallest power of two that is not below n.
  function automatic int pad_pow2(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  // Register stages of a binary adder tree over n leaves.
  function automatic int tree_depth(input int n);
    return $clog2(pad_pow2(n));
  endfunction

  // Accept-edge to output-valid distance: pre-add, lookup, plane stages plus tree.
  function automatic int pipe_latency(input int dw);
    return 3 + tree_depth(dw + 1);
  endfunction

endpackage

// File: rtl/dasym_fir_preadd.sv
module dasym_fir_preadd #(
  parameter int NTAPS = 16,
  parameter int DW    = 8,
  localparam int NPAIR = NTAPS / 2,
  localparam int PDW   = DW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_data,
  output logic                   pre_valid,
  output logic [NPAIR*PDW-1:0]   pre_word
);

  logic [DW-1:0]        tap_q [NTAPS];
  logic [DW-1:0]        tap_d [NTAPS];
  logic                 tap_vld_q;
  logic [NPAIR*PDW-1:0] pre_d;
  logic [NPAIR*PDW-1:0] pre_q;
  logic                 pre_vld_q;

  // Delay line next state: newest sample at index 0.
  always_comb begin
    tap_d[0] = in_data;
    for (int k = 1; k < NTAPS; k++) tap_d[k] = tap_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) tap_q[k] <= '0;
      tap_vld_q <= 1'b0;
    end else begin
      tap_vld_q <= in_valid;
      if (in_valid) tap_q <= tap_d;
    end
  end

  // Mirror-pair pre-addition: tap k and tap NTAPS-1-k share a coefficient.
  always_comb begin
    for (int k = 0; k < NPAIR; k++) begin
      pre_d[k*PDW +: PDW] = PDW'($signed(tap_q[k])) + PDW'($signed(tap_q[NTAPS-1-k]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      pre_vld_q <= 1'b0;
    end else begin
      pre_vld_q <= tap_vld_q;
      if (tap_vld_q) pre_q <= pre_d;
    end
  end

  assign pre_valid = pre_vld_q;
  assign pre_word  = pre_q;

endmodule

// File: rtl/dasym_fir_lut.sv
module dasym_fir_lut #(
  parameter int PW = 4,
  parameter int CW = 10,
  parameter int NB = 9,
  parameter logic [PW*CW-1:0] COEF = '0,
  localparam int LW   = CW + $clog2(PW),
  localparam int NENT = 2 ** PW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [NB*PW-1:0]   addr,
  output logic [NB*LW-1:0]   rd
);

  // Entry a holds the sum of the coefficients whose address bit is set.
  function automatic logic [LW-1:0] entry(input int a);
    logic [LW-1:0] acc;
    acc = '0;
    for (int i = 0; i < PW; i++) begin
      if (((a >> i) & 1) != 0) acc = acc + LW'($signed(COEF[i*CW +: CW]));
    end
    return acc;
  endfunction

  logic [LW-1:0]      tbl [NENT];
  logic [NB*LW-1:0]   rd_d;
  logic [NB*LW-1:0]   rd_q;

  for (genvar a = 0; a < NENT; a++) begin : g_ent
    localparam logic [LW-1:0] VAL = entry(a);
    assign tbl[a] = VAL;
  end

  // One read port per bit plane, all read in the same cycle.
  always_comb begin
    for (int b = 0; b < NB; b++) rd_d[b*LW +: LW] = tbl[addr[b*PW +: PW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (en) rd_q <= rd_d;
  end

  assign rd = rd_q;

endmodule

// File: rtl/dasym_fir_addtree.sv
module dasym_fir_addtree
  import dasym_fir_pkg::*;
#(
  parameter int NLEAF = 9,
  parameter int W     = 22,
  localparam int PAD  = pad_pow2(NLEAF),
  localparam int LVL  = $clog2(PAD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NLEAF*W-1:0] leaf_in,
  output logic               out_valid,
  output logic [W-1:0]       sum_out
);

  logic [W-1:0]   leaf   [PAD];
  logic [W-1:0]   node_q [PAD-1];
  logic [LVL-1:0] vld_d;
  logic [LVL-1:0] vld_q;

  for (genvar p = 0; p < PAD; p++) begin : g_leaf
    if (p < NLEAF) begin : g_real
      assign leaf[p] = leaf_in[p*W +: W];
    end else begin : g_zero
      assign leaf[p] = '0;
    end
  end

  always_comb begin
    vld_d[0] = in_valid;
    for (int s = 1; s < LVL; s++) vld_d[s] = vld_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Heap-indexed tree; every node of one depth loads in the same stage.
  for (genvar i = 0; i < PAD - 1; i++) begin : g_node
    localparam int DEP = $clog2(i + 2) - 1;
    localparam int STG = LVL - 1 - DEP;
    localparam int CL  = 2 * i + 1;
    localparam int CR  = 2 * i + 2;
    logic [W-1:0] op_l;
    logic [W-1:0] op_r;
    logic [W-1:0] sum_d;
    logic [W-1:0] sum_q;
    logic         ld_en;
    if (CL >= PAD - 1) begin : g_from_leaf
      assign op_l = leaf[CL-(PAD-1)];
      assign op_r = leaf[CR-(PAD-1)];
    end else begin : g_from_node
      assign op_l = node_q[CL];
      assign op_r = node_q[CR];
    end
    if (STG == 0) begin : g_en_in
      assign ld_en = in_valid;
    end else begin : g_en_stage
      assign ld_en = vld_q[STG-1];
    end
    always_comb sum_d = op_l + op_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (ld_en) sum_q <= sum_d;
    end
    assign node_q[i] = sum_q;
  end

  assign out_valid = vld_q[LVL-1];
  assign sum_out   = node_q[0];

endmodule

// File: rtl/dasym_fir.sv
module dasym_fir
  import dasym_fir_pkg::*;
#(
  parameter int NTAPS = 16,
  parameter int DW    = 8,
  parameter int CW    = 10,
  parameter int PW    = 4,
  parameter logic [(NTAPS/2)*CW-1:0] COEFS = {10'sd190, 10'sd160, 10'sd110, 10'sd60,
                                              10'sd25,  10'sd0,   -10'sd8,  -10'sd3},
  localparam int NPAIR = NTAPS / 2,
  localparam int PDW   = DW + 1,
  localparam int NB    = PDW,
  localparam int NPART = NPAIR / PW,
  localparam int LW    = CW + $clog2(PW),
  localparam int OW    = PDW + CW + $clog2(NPAIR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Stage 0/1: delay line and mirror-pair pre-add.
  logic                 pre_valid;
  logic [NPAIR*PDW-1:0] pre_word;

  dasym_fir_preadd #(.NTAPS(NTAPS), .DW(DW)) u_preadd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .pre_valid (pre_valid),
    .pre_word  (pre_word)
  );

  // Stage 2: partitioned lookups, one address per bit plane per partition.
  logic [NB*PW-1:0] lut_addr [NPART];
  logic [NB*LW-1:0] lut_rd   [NPART];
  logic             lut_vld_q;

  always_comb begin
    for (int j = 0; j < NPART; j++) begin
      for (int b = 0; b < NB; b++) begin
        for (int i = 0; i < PW; i++) begin
          lut_addr[j][b*PW+i] = pre_word[(j*PW+i)*PDW + b];
        end
      end
    end
  end

  for (genvar j = 0; j < NPART; j++) begin : g_part
    dasym_fir_lut #(
      .PW   (PW),
      .CW   (CW),
      .NB   (NB),
      .COEF (COEFS[j*PW*CW +: PW*CW])
    ) u_lut (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (pre_valid),
      .addr  (lut_addr[j]),
      .rd    (lut_rd[j])
    );
  end

  // Stage 3: combine partitions, weight each plane, negate the sign plane.
  logic [NB*OW-1:0] plane_d;
  logic [NB*OW-1:0] plane_q;
  logic             plane_vld_q;
  logic [OW-1:0]    plane_acc;

  always_comb begin
    plane_acc = '0;
    for (int b = 0; b < NB; b++) begin
      plane_acc = '0;
      for (int j = 0; j < NPART; j++) begin
        plane_acc = plane_acc + OW'($signed(lut_rd[j][b*LW +: LW]));
      end
      plane_acc = plane_acc << b;
      plane_d[b*OW +: OW] = (b == NB - 1) ? (OW'(0) - plane_acc) : plane_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_vld_q   <= 1'b0;
      plane_vld_q <= 1'b0;
      plane_q     <= '0;
    end else begin
      lut_vld_q   <= pre_valid;
      plane_vld_q <= lut_vld_q;
      if (lut_vld_q) plane_q <= plane_d;
    end
  end

  // Stages 4..: pipelined tree over the weighted planes.
  dasym_fir_addtree #(.NLEAF(NB), .W(OW)) u_tree (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (plane_vld_q),
    .leaf_in   (plane_q),
    .out_valid (out_valid),
    .sum_out   (out_data)
  );

endmodule

// File: rtl/dasym_fir_chk.sv
module dasym_fir_chk
  import dasym_fir_pkg::*;
#(
  parameter int NTAPS = 16,
  parameter int DW    = 8,
  parameter int CW    = 10,
  parameter logic [(NTAPS/2)*CW-1:0] COEFS = '0,
  localparam int NPAIR = NTAPS / 2,
  localparam int PDW   = DW + 1,
  localparam int OW    = PDW + CW + $clog2(NPAIR),
  localparam int LAT   = pipe_latency(DW)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [DW-1:0]        in_data,
  input logic                 pre_valid,
  input logic [NPAIR*PDW-1:0] pre_word,
  input logic                 out_valid,
  input logic [OW-1:0]        out_data
);

  function automatic longint out_bound();
    longint s;
    longint c;
    s = 0;
    for (int i = 0; i < NPAIR; i++) begin
      c = longint'($signed(COEFS[i*CW +: CW]));
      s = s + ((c < 0) ? -c : c);
    end
    return s * (longint'(1) << DW);
  endfunction

  localparam longint BOUND = out_bound();

  logic [LAT:0]    vhist_q;
  logic [DW-1:0]   samp_q [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vhist_q <= '0;
      for (int k = 0; k < NTAPS; k++) samp_q[k] <= '0;
    end else begin
      vhist_q <= {vhist_q[LAT-1:0], in_valid};
      if (in_valid) begin
        samp_q[0] <= in_data;
        for (int k = 1; k < NTAPS; k++) samp_q[k] <= samp_q[k-1];
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist_q[LAT]); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R5

  AST_PAIR_PREADD: assert property (@(posedge clk) disable iff (!rst_n)
    pre_valid |-> pre_word[PDW-1:0] ==
      PDW'($signed($past(samp_q[0]))) + PDW'($signed($past(samp_q[NTAPS-1])))); // R2

  AST_OUT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(out_data)) <= BOUND &&
                   longint'($signed(out_data)) >= -BOUND)); // R2

endmodule

bind dasym_fir dasym_fir_chk #(
  .NTAPS (NTAPS),
  .DW    (DW),
  .CW    (CW),
  .COEFS (COEFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .pre_valid (pre_valid),
  .pre_word  (pre_word),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/dasym_fir_tb.sv
`timescale 1ns/1ps
module dasym_fir_tb;

  localparam int NT = 16;
  localparam int OW = 22;
  localparam logic [79:0] LP_SET = {10'sd190, 10'sd160, 10'sd110, 10'sd60,
                                    10'sd25,  10'sd0,   -10'sd8,  -10'sd3};
  localparam logic [79:0] HP_SET = {10'sd511, -10'sd512, 10'sd250, -10'sd120,
                                    10'sd60,  -10'sd30,  10'sd12,  -10'sd7};

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_data;
  logic          ov_lp, ov_hp;
  logic [OW-1:0] od_lp, od_hp;

  dasym_fir #(.COEFS(LP_SET)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov_lp), .out_data(od_lp)
  );

  dasym_fir #(.COEFS(HP_SET)) u_dut_hp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov_hp), .out_data(od_hp)
  );

  int      n_tests;
  int      n_fail;
  longint  cyc;
  bit      done;
  int      hist [NT];
  int      h_lp [8];
  int      h_hp [8];
  longint  due_q [$];
  longint  exp_lp_q [$];
  longint  exp_hp_q [$];
  string   tag_q [$];
  longint  last_lp, last_hp;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string req, input longint act, input longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic observe();
    bit due;
    due = (due_q.size() > 0) && (due_q[0] == cyc);
    chk("R3 valid timing", longint'(ov_lp), longint'(due));
    chk("R7 valid timing", longint'(ov_hp), longint'(due));
    if (due) begin
      chk(tag_q[0], longint'($signed(od_lp)), exp_lp_q[0]);
      chk("R7 coefficient set", longint'($signed(od_hp)), exp_hp_q[0]);
      last_lp = exp_lp_q[0];
      last_hp = exp_hp_q[0];
      void'(due_q.pop_front());
      void'(exp_lp_q.pop_front());
      void'(exp_hp_q.pop_front());
      void'(tag_q.pop_front());
    end else begin
      chk("R5 hold", longint'($signed(od_lp)), last_lp);
      chk("R5 hold", longint'($signed(od_hp)), last_hp);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d, input string req);
    longint ylp, yhp;
    @(negedge clk);
    observe();
    in_valid = v;
    in_data  = d;
    if (v) begin
      for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'($signed(d));
      ylp = 0;
      yhp = 0;
      for (int k = 0; k < 8; k++) begin
        ylp += longint'(h_lp[k]) * longint'(hist[k] + hist[NT-1-k]);
        yhp += longint'(h_hp[k]) * longint'(hist[k] + hist[NT-1-k]);
      end
      due_q.push_back(cyc + 8);
      exp_lp_q.push_back(ylp);
      exp_hp_q.push_back(yhp);
      tag_q.push_back(req);
    end
  endtask

  // Idle cycles with junk on in_data: R4 says it must not reach the history.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'($urandom), "R4");
  endtask

  initial begin
    h_lp = '{-3, -8, 0, 25, 60, 110, 160, 190};
    h_hp = '{-7, 12, -30, 60, -120, 250, -512, 511};
    for (int i = 0; i < NT; i++) hist[i] = 0;
    n_tests = 0; n_fail = 0; cyc = 0; done = 0;
    last_lp = 0; last_hp = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;

    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 out_valid in reset", longint'(ov_lp), 0);
      chk("R1 out_data in reset", longint'($signed(od_lp)), 0);
      chk("R1 hp out_data in reset", longint'($signed(od_hp)), 0);
    end
    rst_n = 1'b1;
    idle(6);

    // R2: unit impulse gives the mirrored coefficient sequence
    step(1'b1, 8'd1, "R2 impulse");
    for (int i = 0; i < 17; i++) step(1'b1, 8'd0, "R2 impulse tail");
    idle(10);

    // R6: most negative impulse and sustained extremes
    step(1'b1, 8'h80, "R6 negative impulse");
    for (int i = 0; i < 17; i++) step(1'b1, 8'd0, "R6 impulse tail");
    for (int i = 0; i < 20; i++) step(1'b1, 8'h7F, "R2 positive step");
    for (int i = 0; i < 20; i++) step(1'b1, 8'h80, "R6 negative step");
    idle(10);

    // R8: every input value, back to back
    for (int v = 0; v < 256; v++) step(1'b1, 8'(v), "R8 back-to-back sweep");
    idle(10);

    // R3 / R4 / R5: random data with gaps in in_valid
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 10) < 6;
      step(v, 8'($urandom), "R3 gapped random");
    end
    idle(12);

    chk("R3 all outputs delivered", longint'(due_q.size()), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule